// File: doc/BRIEF.md
# Quick add/subtract sequencer

This block takes one 16-bit opcode at a time from the quick add/subtract group and plays out the cycles that instruction needs. Each cycle is a memory port command (idle, read word, write word or prefetch) together with its address. One cycle carries a trigger to the arithmetic unit. At the end comes a completion pulse, and for the post-increment form it also requests that the address register be advanced. The arithmetic itself lives elsewhere. This block supplies the unit with the operation, the operand size and the immediate value decoded from the opcode.

The cycle list depends on two things: the operand size and the destination form. The supported forms are a data register, an address register, indirect through an address register, and indirect with post-increment. A 32-bit memory operand is moved as two 16-bit words in a fixed order. The address register's current value comes in on `an_val_i`, and the block names that register on `an_idx_o`. An opcode outside the group, or one with an unsupported destination form, is flagged as illegal and produces no bus activity.

Top module: `quick_addsub_seq`

## Requirements
- R1: An accepted opcode is legal when bits 15:12 equal 5, bits 7:6 are not 3, and the mode field (bits 5:3) is 0 to 3. Any other accepted opcode raises `illegal_o` for exactly the one cycle after acceptance, with `bus_cmd_o` idle and no `done_o`. `ready_o` returns in the cycle after that.
- R2: From the cycle after acceptance through the `done_o` cycle, the decoded fields are held on the outputs. `alu_sub_o` equals opcode bit 8 (1 = subtract). `alu_size_o` equals bits 7:6 (0 byte, 1 word, 2 long). `alu_imm_o` equals bits 11:9, with 0 mapped to 8.
- R3: Mode 0 with byte or word size runs a single cycle: prefetch (`bus_cmd_o` = 3) with `alu_go_o` high. The other command codes are 0 idle, 1 read and 2 write.
- R4: Mode 0 with long size, or mode 1 with any size, runs three cycles: prefetch with `alu_go_o`, then idle, then idle.
- R5: Modes 2 and 3 with byte or word size run three cycles: read at A, prefetch with `alu_go_o`, then write at A. A is the value of `an_val_i`.
- R6: Modes 2 and 3 with long size run five cycles in this order: read at A, read at A+2, prefetch with `alu_go_o`, write at A+2, write at A.
- R7: In the `done_o` cycle of a mode 3 opcode, `inc_o` is high and `inc_amt_o` is 1 for byte, 2 for word and 4 for long. Otherwise `inc_o` and `inc_amt_o` are 0.
- R8: Acceptance happens only on a clock edge with `op_valid_i` and `ready_o` both high. `done_o` is high for the one cycle after the last scripted cycle. `ready_o` is high only when the block is idle, so `op_valid_i` has no effect while the block is busy.
- R9: While reset is asserted, and right after it, `ready_o` is 1, `bus_cmd_o` is idle, and `alu_go_o`, `done_o`, `inc_o` and `illegal_o` are 0.
- R10: While busy, `an_idx_o` equals opcode bits 2:0. During read and write cycles, `bus_addr_o` is `an_val_i` plus the step's offset of 0 or 2. In all other cycles it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode offered |
| op_i | input | 16 | Opcode |
| ready_o | output | 1 | Idle; accepts an opcode this cycle |
| an_val_i | input | ADDR_W | Value of the address register named by an_idx_o |
| an_idx_o | output | 3 | Address register index |
| bus_cmd_o | output | 2 | 0 idle, 1 read, 2 write, 3 prefetch |
| bus_addr_o | output | ADDR_W | Word address for read and write |
| alu_go_o | output | 1 | Perform the arithmetic this cycle |
| alu_sub_o | output | 1 | 1 = subtract |
| alu_size_o | output | 2 | Operand size |
| alu_imm_o | output | 4 | Quick immediate, 1 to 8 |
| inc_o | output | 1 | Advance the address register |
| inc_amt_o | output | 3 | Advance amount |
| done_o | output | 1 | Sequence complete |
| illegal_o | output | 1 | Opcode rejected |

## Verification
Opcodes are issued for every size in each of the four destination forms, so that each of the four cycle scripts is seen. One byte opcode with an address-register destination checks that mode 1 takes the long script whatever the size. Two post-increment long opcodes on the same register are issued back to back. The second run's addresses show whether the first advanced the register by 4, and repeated word and byte post-increments show the strides of 2 and 1. Several illegal opcodes are offered (size 3, mode 4, mode 7, and a foreign group), along with an immediate field of 0 that must read as 8. An opcode is also held on the input while a long sequence is running, to show that it is ignored while busy.

// File: rtl/qas_pkg.sv
package qas_pkg;
  localparam int OP_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_PREF  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SC_REG_SHORT,
    SC_REG_LONG,
    SC_MEM_SHORT,
    SC_MEM_LONG
  } script_e;

  typedef struct packed {
    bus_cmd_e cmd;
    logic     hi_off;
    logic     go;
    logic     last;
  } step_t;
endpackage

// File: rtl/qas_decode.sv
module qas_decode
  import qas_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            legal_o,
  output script_e         script_o,
  output logic            postinc_o,
  output logic [2:0]      inc_amt_o,
  output logic            sub_o,
  output logic [1:0]      size_o,
  output logic [3:0]      imm_o,
  output logic [2:0]      reg_o
);
  logic [2:0] mode;
  logic [1:0] size;

  assign mode   = op_i[5:3];
  assign size   = op_i[7:6];
  assign sub_o  = op_i[8];
  assign size_o = size;
  assign reg_o  = op_i[2:0];
  assign imm_o  = (op_i[11:9] == 3'd0) ? 4'd8 : {1'b0, op_i[11:9]};

  assign legal_o   = (op_i[15:12] == 4'h5) && (size != 2'd3) && (mode <= 3'd3);
  assign postinc_o = (mode == 3'd3);

  always_comb begin
    unique case (size)
      2'd0:    inc_amt_o = 3'd1;
      2'd1:    inc_amt_o = 3'd2;
      default: inc_amt_o = 3'd4;
    endcase
  end

  always_comb begin
    if (mode == 3'd0 && size != 2'd2)  script_o = SC_REG_SHORT;
    else if (mode <= 3'd1)             script_o = SC_REG_LONG;
    else if (size != 2'd2)             script_o = SC_MEM_SHORT;
    else                               script_o = SC_MEM_LONG;
  end
endmodule

// File: rtl/qas_script.sv
module qas_script
  import qas_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  script_e           script_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);
  always_comb begin
    step_o = '{cmd: BUS_IDLE, hi_off: 1'b0, go: 1'b0, last: 1'b1};
    unique case (script_i)
      SC_REG_SHORT: step_o = '{cmd: BUS_PREF, hi_off: 1'b0, go: 1'b1, last: 1'b1};
      SC_REG_LONG: begin
        case (idx_i)
          'd0:     step_o = '{cmd: BUS_PREF, hi_off: 1'b0, go: 1'b1, last: 1'b0};
          'd1:     step_o = '{cmd: BUS_IDLE, hi_off: 1'b0, go: 1'b0, last: 1'b0};
          default: step_o = '{cmd: BUS_IDLE, hi_off: 1'b0, go: 1'b0, last: 1'b1};
        endcase
      end
      SC_MEM_SHORT: begin
        case (idx_i)
          'd0:     step_o = '{cmd: BUS_READ,  hi_off: 1'b0, go: 1'b0, last: 1'b0};
          'd1:     step_o = '{cmd: BUS_PREF,  hi_off: 1'b0, go: 1'b1, last: 1'b0};
          default: step_o = '{cmd: BUS_WRITE, hi_off: 1'b0, go: 1'b0, last: 1'b1};
        endcase
      end
      SC_MEM_LONG: begin
        // high word lives at A, low word at A+2; writes go low first
        case (idx_i)
          'd0:     step_o = '{cmd: BUS_READ,  hi_off: 1'b0, go: 1'b0, last: 1'b0};
          'd1:     step_o = '{cmd: BUS_READ,  hi_off: 1'b1, go: 1'b0, last: 1'b0};
          'd2:     step_o = '{cmd: BUS_PREF,  hi_off: 1'b0, go: 1'b1, last: 1'b0};
          'd3:     step_o = '{cmd: BUS_WRITE, hi_off: 1'b1, go: 1'b0, last: 1'b0};
          default: step_o = '{cmd: BUS_WRITE, hi_off: 1'b0, go: 1'b0, last: 1'b1};
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qas_addr.sv
module qas_addr
  import qas_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  bus_cmd_e          cmd_i,
  input  logic              hi_off_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  always_comb begin
    if (cmd_i == BUS_READ || cmd_i == BUS_WRITE)
      addr_o = hi_off_i ? base_i + WORD_STEP : base_i;
    else
      addr_o = '0;
  end
endmodule

// File: rtl/quick_addsub_seq.sv
module quick_addsub_seq
  import qas_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_STEPS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [15:0]       op_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] an_val_i,
  output logic [2:0]        an_idx_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              alu_go_o,
  output logic              alu_sub_o,
  output logic [1:0]        alu_size_o,
  output logic [3:0]        alu_imm_o,
  output logic              inc_o,
  output logic [2:0]        inc_amt_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam int STEP_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE, ST_ILL} state_e;

  state_e            state_q;
  logic [OP_W-1:0]   op_q;
  logic [STEP_W-1:0] step_q;

  logic [OP_W-1:0] dec_op;
  logic            dec_legal, dec_postinc, dec_sub;
  script_e         dec_script;
  logic [2:0]      dec_amt, dec_reg;
  logic [1:0]      dec_size;
  logic [3:0]      dec_imm;
  step_t           cur_step;
  bus_cmd_e        cmd;
  logic            accept;

  assign accept = op_valid_i && (state_q == ST_IDLE);
  assign dec_op = (state_q == ST_IDLE) ? op_i : op_q;

  qas_decode u_dec (
    .op_i      (dec_op),
    .legal_o   (dec_legal),
    .script_o  (dec_script),
    .postinc_o (dec_postinc),
    .inc_amt_o (dec_amt),
    .sub_o     (dec_sub),
    .size_o    (dec_size),
    .imm_o     (dec_imm),
    .reg_o     (dec_reg)
  );

  qas_script #(.STEP_W(STEP_W)) u_script (
    .script_i (dec_script),
    .idx_i    (step_q),
    .step_o   (cur_step)
  );

  assign cmd = (state_q == ST_RUN) ? cur_step.cmd : BUS_IDLE;

  qas_addr #(.ADDR_W(ADDR_W)) u_addr (
    .cmd_i    (cmd),
    .hi_off_i (cur_step.hi_off),
    .base_i   (an_val_i),
    .addr_o   (bus_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= op_i;
          step_q  <= '0;
          state_q <= dec_legal ? ST_RUN : ST_ILL;
        end
        ST_RUN: begin
          if (cur_step.last) state_q <= ST_DONE;
          else               step_q  <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign bus_cmd_o  = cmd;
  assign alu_go_o   = (state_q == ST_RUN) && cur_step.go;
  assign done_o     = (state_q == ST_DONE);
  assign illegal_o  = (state_q == ST_ILL);
  assign inc_o      = done_o && dec_postinc;
  assign inc_amt_o  = inc_o ? dec_amt : 3'd0;
  assign alu_sub_o  = dec_sub;
  assign alu_size_o = dec_size;
  assign alu_imm_o  = dec_imm;
  assign an_idx_o   = op_q[2:0];

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && op_valid_i) |=> !ready_o);
  // R8
  done_then_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (bus_cmd_o == BUS_IDLE) && !done_o && !alu_go_o);
  // R1
  illegal_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> ready_o);
  // R7
  inc_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> done_o && $onehot(inc_amt_o));
  // R3
  go_on_pref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_go_o |-> (bus_cmd_o == BUS_PREF));
  // R5
  write_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == BUS_WRITE) |-> !$past(ready_o));
  // R10
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == BUS_IDLE || bus_cmd_o == BUS_PREF) |-> (bus_addr_o == '0));
endmodule

// File: tb/quick_addsub_seq_tb_top.sv
`timescale 1ns/1ps
module quick_addsub_seq_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [15:0]   op = '0;
  logic          ready;
  logic [AW-1:0] an_val;
  logic [2:0]    an_idx;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          alu_go, alu_sub;
  logic [1:0]    alu_size;
  logic [3:0]    alu_imm;
  logic          inc;
  logic [2:0]    inc_amt;
  logic          done, illegal;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  quick_addsub_seq #(.ADDR_W(AW), .MAX_STEPS(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .ready_o(ready),
    .an_val_i(an_val), .an_idx_o(an_idx), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .alu_go_o(alu_go), .alu_sub_o(alu_sub), .alu_size_o(alu_size), .alu_imm_o(alu_imm),
    .inc_o(inc), .inc_amt_o(inc_amt), .done_o(done), .illegal_o(illegal)
  );

  // environment register file, advanced by the DUT's requests
  logic [AW-1:0] env_areg [8];
  assign an_val = env_areg[an_idx];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) env_areg[i] <= AW'(24'h001000 + i * 24'h000100);
    end else if (inc) begin
      env_areg[an_idx] <= env_areg[an_idx] + AW'(inc_amt);
    end
  end

  typedef struct packed {
    logic          rdy;
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic          go;
    logic          dn;
    logic          inc;
    logic [2:0]    amt;
    logic          ill;
    logic          fld;
    logic          sub;
    logic [1:0]    size;
    logic [3:0]    imm;
    logic [2:0]    idx;
    logic [3:0]    req;
  } exp_t;

  exp_t exp_q[$];
  exp_t tmpl;
  logic cur_ready = 1'b1;
  logic [AW-1:0] model_areg [8];

  task automatic push(input logic [1:0] c, input logic [AW-1:0] a, input logic g, input int r);
    exp_t e;
    e = tmpl;
    e.cmd = c; e.addr = a; e.go = g; e.req = 4'(r);
    exp_q.push_back(e);
  endtask

  // reference model: build the expected cycle list at the accepting edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) model_areg[i] = AW'(24'h001000 + i * 24'h000100);
    end else if (cur_ready && op_valid) begin
      logic [1:0] sz;
      logic [2:0] md, rg;
      logic [AW-1:0] base;
      logic [2:0] amt;
      sz = op[7:6]; md = op[5:3]; rg = op[2:0];
      base = model_areg[rg];
      amt = (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
      tmpl = '0;
      if (!(op[15:12] == 4'h5 && sz != 2'd3 && md <= 3'd3)) begin
        tmpl.ill = 1'b1; tmpl.req = 4'd1; // R1
        exp_q.push_back(tmpl);
      end else begin
        tmpl.fld = 1'b1; tmpl.sub = op[8]; tmpl.size = sz;
        tmpl.imm = (op[11:9] == 3'd0) ? 4'd8 : {1'b0, op[11:9]};
        tmpl.idx = rg;
        if (md == 3'd0 && sz != 2'd2) begin
          push(2'd3, '0, 1'b1, 3);                     // R3
        end else if (md <= 3'd1) begin
          push(2'd3, '0, 1'b1, 4);                     // R4
          push(2'd0, '0, 1'b0, 4);
          push(2'd0, '0, 1'b0, 4);
        end else if (sz != 2'd2) begin
          push(2'd1, base, 1'b0, 5);                   // R5
          push(2'd3, '0, 1'b1, 5);
          push(2'd2, base, 1'b0, 5);
        end else begin
          push(2'd1, base, 1'b0, 6);                   // R6
          push(2'd1, base + AW'(2), 1'b0, 6);
          push(2'd3, '0, 1'b1, 6);
          push(2'd2, base + AW'(2), 1'b0, 6);
          push(2'd2, base, 1'b0, 6);
        end
        tmpl.dn = 1'b1;
        if (md == 3'd3) begin
          tmpl.inc = 1'b1; tmpl.amt = amt; tmpl.req = 4'd7; // R7
          model_areg[rg] = model_areg[rg] + AW'(amt);
        end else begin
          tmpl.req = 4'd8;                             // R8
        end
        exp_q.push_back(tmpl);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      checks++; // R9
      if ({ready, bus_cmd, alu_go, done, inc, illegal} !== 7'b1_00_0000) begin
        failures++;
        $display("FAIL R9 reset state act=%b exp=%b", {ready, bus_cmd, alu_go, done, inc, illegal}, 7'b1_00_0000);
      end
      cur_ready = 1'b1;
    end else begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin e = '0; e.rdy = 1'b1; e.req = 4'd8; end
      cur_ready = e.rdy;
      checks++;
      if ({ready, bus_cmd, alu_go, done, inc, illegal} !== {e.rdy, e.cmd, e.go, e.dn, e.inc, e.ill}) begin
        failures++;
        $display("FAIL R%0d control act=%b exp=%b", e.req,
                 {ready, bus_cmd, alu_go, done, inc, illegal}, {e.rdy, e.cmd, e.go, e.dn, e.inc, e.ill});
      end
      checks++; // R10 address
      if (bus_addr !== e.addr) begin
        failures++;
        $display("FAIL R10 addr act=%h exp=%h (script R%0d)", bus_addr, e.addr, e.req);
      end
      checks++; // R7 amount
      if (inc_amt !== e.amt) begin
        failures++;
        $display("FAIL R7 inc_amt act=%0d exp=%0d", inc_amt, e.amt);
      end
      if (e.fld) begin
        checks++; // R2
        if ({alu_sub, alu_size, alu_imm} !== {e.sub, e.size, e.imm}) begin
          failures++;
          $display("FAIL R2 fields act=%b exp=%b", {alu_sub, alu_size, alu_imm}, {e.sub, e.size, e.imm});
        end
        checks++; // R10 index
        if (an_idx !== e.idx) begin
          failures++;
          $display("FAIL R10 an_idx act=%0d exp=%0d", an_idx, e.idx);
        end
      end
    end
  end

  task automatic issue(input logic [15:0] o);
    @(negedge clk);
    while (!ready) @(negedge clk);
    #1 op = o; op_valid = 1'b1;
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  localparam int N_OPS = 18;
  logic [15:0] ops [N_OPS] = '{
    16'h5602, // ADD byte #3 D2          R3
    16'h5145, // SUB word #8 D5          R3, R2 imm 0->8
    16'h5280, // ADD long #1 D0          R4
    16'h544B, // ADD word #2 A3          R4
    16'h5209, // ADD byte #1 A1          R4
    16'h5914, // SUB byte #4 (A4)        R5
    16'h5E5A, // ADD word #7 (A2)+       R5 R7
    16'h5E5A, // again: A2 advanced by 2
    16'h521A, // ADD byte (A2)+          R7 stride 1
    16'h5D96, // SUB long #6 (A6)        R6
    16'h5A9E, // ADD long #5 (A6)+       R6 R7
    16'h5A9E, // again: A6 advanced by 4
    16'h50C0, // size 3                  R1
    16'h5020, // mode 4                  R1
    16'h5038, // mode 7                  R1
    16'h4E71, // foreign group           R1
    16'h5D9E, // SUB long (A6)+
    16'h5100  // SUB byte #8 D0
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < N_OPS; i++) issue(ops[i]);
    // R8: an opcode held while a long sequence runs is ignored
    issue(16'h5A9E);
    @(negedge clk);
    #1 op = 16'h5602; op_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 op_valid = 1'b0;
    repeat (12) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule